// File: doc/BRIEF.md
# Interrupt controller error status unit

This unit keeps one sticky flag for each error that a local interrupt controller can detect, and raises an error interrupt toward the core. Four causes come in as detection pulses from logic outside the unit:

- a checksum error on a sent message,
- a checksum error on a received message,
- a sent message that no receiver accepted,
- a received message that no receiver accepted, this unit included.

The unit finds the other three causes on its own:

- It compares vectors on the send path against the lowest legal vector.
- It does the same on the receive, local-table and self-interrupt paths.
- It decodes register accesses that land in reserved 16-byte slots of a 4 KB window. The window sits at a programmable base.

Software latches and clears the flags by writing the status slot. The readable copy of the flags then appears on the `status` port. An error entry, written through the same access bus, holds the vector delivered with the interrupt and a mask bit. When the mask bit is set the interrupt is held back, but the flags are still recorded. The access bus carries addresses at 16-byte granularity. `acc_addr` holds address bits 31 down to 4, so its low 8 bits are the slot number inside the window.

Top module: `irq_err_status`

## Requirements
- R1: Status layout. Bit 0 is the send checksum error and bit 1 the receive checksum error. Bit 2 is the send accept error and bit 3 the receive accept error. Bit 5 is the send illegal vector, bit 6 the receive illegal vector, and bit 7 the illegal register address. Bit 4 always reads 0.
- R2: A pulse on `det_send_csum`, `det_recv_csum`, `det_send_nacc` or `det_recv_nacc` sets flag bit 0, 1, 2 or 3 respectively. The flag stays set until the next status write.
- R3: When `send_vec_vld` is high and `send_vec` is below 16, flag bit 5 is set. Vectors from 16 to 255 have no effect.
- R4: An illegal vector (below 16) on a valid receive, local-table or self-interrupt path sets flag bit 6. Vectors of 16 or more on these paths have no effect.
- R5: An access (read or write) sets flag bit 7 when both hold:
  - `acc_addr[27:8]` equals `win_base`.
  - The slot `acc_addr[7:0]` is reserved.
  
  The implemented slots are 0x02, 0x03, 0x08 to 0x0B and 0x0D to 0x3F. Every other slot is reserved. Accesses outside the window have no effect.
- R6: A write to slot 0x28 of the window is a status write:
  - On the next cycle, `status` shows the flags as they stood before that cycle.
  - The internal flags are cleared.
  - A cause detected in the same cycle stays set.
- R7: `err_irq` pulses high for one cycle, in the cycle after any flag goes from clear to set, if the mask is clear. A cause whose flag is already set raises no interrupt.
- R8: While the error entry's mask bit is set, `err_irq` stays low, but the flags are still recorded.
- R9: A write to slot 0x37 loads the error entry. Data bits [7:0] give the vector and data bit 8 gives the mask. `err_vec` takes the entry's vector when `err_irq` is raised and holds it at all other times.
- R10: While `rst` is high:
  - `status`, `err_irq` and `err_vec` are zero.
  - All flags are clear.
  - The error entry holds mask 1 and vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_send_csum | input | 1 | Send checksum error pulse |
| det_recv_csum | input | 1 | Receive checksum error pulse |
| det_send_nacc | input | 1 | Sent message not accepted pulse |
| det_recv_nacc | input | 1 | Received message not accepted pulse |
| send_vec_vld | input | 1 | Send vector under test is valid |
| send_vec | input | 8 | Vector of the message being sent |
| recv_vec_vld | input | 1 | Received vector is valid |
| recv_vec | input | 8 | Vector of a received message |
| lvt_vec_vld | input | 1 | Local-table vector is valid |
| lvt_vec | input | 8 | Vector from a local-table entry |
| self_vec_vld | input | 1 | Self-interrupt vector is valid |
| self_vec | input | 8 | Vector of a self-interrupt |
| win_base | input | 20 | Register window base, address bits 31:12 |
| acc_vld | input | 1 | Register access strobe |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 28 | Access address, bits 31:4 |
| acc_wdata | input | 9 | Write data: [7:0] vector, [8] mask |
| status | output | 8 | Readable copy of the flags |
| err_irq | output | 1 | Error interrupt request pulse |
| err_vec | output | 8 | Vector delivered with the interrupt |

## Verification
The bench goes after the vector boundary at 15 and 16 on every path. A comparator that is off by one would flag a legal vector 16 or miss vector 15. It probes reserved slots at the edges of the implemented ranges (0x01, 0x04, 0x0C, 0x40, 0xFF) against 0x02 and 0x3F, and repeats a reserved access with the base changed. A wrong decode would set bit 7 for a legal or out-of-window access. It places detections in the same cycle as a status write, which catches a design that drops the new cause or folds it into the latched copy. It re-detects an already-set cause, which exposes an interrupt raised on level instead of on the set edge. It also toggles the mask with flags pending, which shows an interrupt leaking through the mask or flags lost while masked.

// File: rtl/irq_err_pkg.sv
package irq_err_pkg;
  localparam int NB = 8;

  localparam int B_SEND_CSUM = 0;
  localparam int B_RECV_CSUM = 1;
  localparam int B_SEND_NACC = 2;
  localparam int B_RECV_NACC = 3;
  localparam int B_SEND_BADV = 5;
  localparam int B_RECV_BADV = 6;
  localparam int B_BAD_REG   = 7;

  localparam int SLOT_W = 8;
  localparam logic [SLOT_W-1:0] STATUS_SLOT = 8'h28;
  localparam logic [SLOT_W-1:0] ENTRY_SLOT  = 8'h37;

  typedef logic [NB-1:0] err_word_t;

  function automatic logic slot_implemented(input logic [SLOT_W-1:0] s);
    return (s == 8'h02) || (s == 8'h03) ||
           ((s >= 8'h08) && (s <= 8'h0B)) ||
           ((s >= 8'h0D) && (s <= 8'h3F));
  endfunction
endpackage

// File: rtl/irq_err_vec_chk.sv
module irq_err_vec_chk #(
  parameter int VEC_W = 8,
  parameter int LIMIT = 16
) (
  input  logic             vld,
  input  logic [VEC_W-1:0] vec,
  output logic             bad
);
  localparam logic [VEC_W-1:0] LIM = VEC_W'(LIMIT);

  always_comb bad = vld && (vec < LIM);
endmodule

// File: rtl/irq_err_reg_dec.sv
module irq_err_reg_dec
  import irq_err_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_W    = 12,
  parameter int SLOT_LSB = 4
) (
  input  logic                       acc_vld,
  input  logic                       acc_wr,
  input  logic [ADDR_W-1:SLOT_LSB]   acc_addr,
  input  logic [ADDR_W-1:WIN_W]      win_base,
  output logic                       rsv_hit,
  output logic                       stat_wr,
  output logic                       entry_wr
);
  logic              in_win;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    in_win   = acc_vld && (acc_addr[ADDR_W-1:WIN_W] == win_base);
    slot     = acc_addr[WIN_W-1:SLOT_LSB];
    rsv_hit  = in_win && !slot_implemented(slot);
    stat_wr  = in_win && acc_wr && (slot == STATUS_SLOT);
    entry_wr = in_win && acc_wr && (slot == ENTRY_SLOT);
  end
endmodule

// File: rtl/irq_err_flags.sv
module irq_err_flags
  import irq_err_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  err_word_t sets,
  input  logic      clr,
  output err_word_t flags_q,
  output err_word_t copy_q,
  output err_word_t rise
);
  err_word_t base_w;

  always_comb begin
    base_w = clr ? '0 : flags_q;
    rise   = sets & ~base_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      copy_q  <= '0;
    end else begin
      if (clr) copy_q <= flags_q;
      flags_q <= base_w | sets;
    end
  end
endmodule

// File: rtl/irq_err_notify.sv
module irq_err_notify #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_any,
  input  logic             entry_wr,
  input  logic [VEC_W:0]   wdata,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);
  logic             mask_q;
  logic [VEC_W-1:0] evec_q;
  logic             fire;

  always_comb fire = rise_any && !mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      evec_q <= '0;
      irq    <= 1'b0;
      vec    <= '0;
    end else begin
      irq <= fire;
      if (fire) vec <= evec_q;
      if (entry_wr) begin
        mask_q <= wdata[VEC_W];
        evec_q <= wdata[VEC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_err_status.sv
module irq_err_status
  import irq_err_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_W    = 12,
  parameter int SLOT_LSB = 4,
  parameter int VEC_W    = 8,
  parameter int BAD_LIM  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     det_send_csum,
  input  logic                     det_recv_csum,
  input  logic                     det_send_nacc,
  input  logic                     det_recv_nacc,
  input  logic                     send_vec_vld,
  input  logic [VEC_W-1:0]         send_vec,
  input  logic                     recv_vec_vld,
  input  logic [VEC_W-1:0]         recv_vec,
  input  logic                     lvt_vec_vld,
  input  logic [VEC_W-1:0]         lvt_vec,
  input  logic                     self_vec_vld,
  input  logic [VEC_W-1:0]         self_vec,
  input  logic [ADDR_W-1:WIN_W]    win_base,
  input  logic                     acc_vld,
  input  logic                     acc_wr,
  input  logic [ADDR_W-1:SLOT_LSB] acc_addr,
  input  logic [VEC_W:0]           acc_wdata,
  output logic [NB-1:0]            status,
  output logic                     err_irq,
  output logic [VEC_W-1:0]         err_vec
);
  localparam int NPATH = 4;

  logic [NPATH-1:0]            pvld;
  logic [NPATH-1:0][VEC_W-1:0] pvec;
  logic [NPATH-1:0]            pbad;
  logic                        rsv_hit;
  logic                        stat_wr;
  logic                        entry_wr;
  err_word_t                   sets;
  err_word_t                   flags_q;
  err_word_t                   copy_q;
  err_word_t                   rise;

  always_comb begin
    pvld = {self_vec_vld, lvt_vec_vld, recv_vec_vld, send_vec_vld};
    pvec = {self_vec, lvt_vec, recv_vec, send_vec};
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_vchk
    irq_err_vec_chk #(.VEC_W(VEC_W), .LIMIT(BAD_LIM)) u_vchk (
      .vld(pvld[g]),
      .vec(pvec[g]),
      .bad(pbad[g])
    );
  end

  irq_err_reg_dec #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .SLOT_LSB(SLOT_LSB)) u_dec (
    .acc_vld (acc_vld),
    .acc_wr  (acc_wr),
    .acc_addr(acc_addr),
    .win_base(win_base),
    .rsv_hit (rsv_hit),
    .stat_wr (stat_wr),
    .entry_wr(entry_wr)
  );

  always_comb begin
    sets              = '0;
    sets[B_SEND_CSUM] = det_send_csum;
    sets[B_RECV_CSUM] = det_recv_csum;
    sets[B_SEND_NACC] = det_send_nacc;
    sets[B_RECV_NACC] = det_recv_nacc;
    sets[B_SEND_BADV] = pbad[0];
    sets[B_RECV_BADV] = |pbad[NPATH-1:1];
    sets[B_BAD_REG]   = rsv_hit;
  end

  irq_err_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .sets   (sets),
    .clr    (stat_wr),
    .flags_q(flags_q),
    .copy_q (copy_q),
    .rise   (rise)
  );

  irq_err_notify #(.VEC_W(VEC_W)) u_note (
    .clk     (clk),
    .rst     (rst),
    .rise_any(|rise),
    .entry_wr(entry_wr),
    .wdata   (acc_wdata),
    .irq     (err_irq),
    .vec     (err_vec)
  );

  always_comb status = copy_q;
endmodule

// File: rtl/irq_err_status_chk.sv
module irq_err_status_chk #(
  parameter int NB    = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NB-1:0]    status,
  input logic             err_irq,
  input logic [VEC_W-1:0] err_vec,
  input logic [NB-1:0]    sets,
  input logic             entry_wr,
  input logic [VEC_W:0]   acc_wdata
);
  logic trk_mask;

  always_ff @(posedge clk) begin
    if (rst) trk_mask <= 1'b1;
    else if (entry_wr) trk_mask <= acc_wdata[VEC_W];
  end

  AST_BIT4_ZERO: assert property (@(posedge clk) disable iff (rst) status[4] == 1'b0); // R1
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst) !err_irq |-> $stable(err_vec)); // R9
  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst) (sets == '0) |=> !err_irq); // R7
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst) trk_mask |=> !err_irq); // R8
endmodule

module irq_err_flags_chk #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [NB-1:0] sets,
  input logic          clr,
  input logic [NB-1:0] flags_q,
  input logic [NB-1:0] copy_q,
  input logic [NB-1:0] rise
);
  AST_STICKY: assert property (@(posedge clk) disable iff (rst) !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R2
  AST_COPY_LATCH: assert property (@(posedge clk) disable iff (rst) clr |=> (copy_q == $past(flags_q))); // R6
  AST_RISE_LANDS: assert property (@(posedge clk) disable iff (rst) (rise != '0) |=> ((flags_q & $past(rise)) == $past(rise))); // R7
  AST_SETS_KEPT: assert property (@(posedge clk) disable iff (rst) (sets != '0) |=> ((flags_q & $past(sets)) == $past(sets))); // R6
endmodule

bind irq_err_status irq_err_status_chk #(.NB(irq_err_pkg::NB), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .status   (status),
  .err_irq  (err_irq),
  .err_vec  (err_vec),
  .sets     (sets),
  .entry_wr (entry_wr),
  .acc_wdata(acc_wdata)
);

bind irq_err_flags irq_err_flags_chk #(.NB(irq_err_pkg::NB)) u_fchk (
  .clk    (clk),
  .rst    (rst),
  .sets   (sets),
  .clr    (clr),
  .flags_q(flags_q),
  .copy_q (copy_q),
  .rise   (rise)
);

// File: tb/irq_err_status_bench.sv
`timescale 1ns/1ps
module irq_err_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        det_send_csum, det_recv_csum, det_send_nacc, det_recv_nacc;
  logic        send_vec_vld, recv_vec_vld, lvt_vec_vld, self_vec_vld;
  logic [7:0]  send_vec, recv_vec, lvt_vec, self_vec;
  logic [19:0] win_base;
  logic        acc_vld, acc_wr;
  logic [27:0] acc_addr;
  logic [8:0]  acc_wdata;
  logic [7:0]  status;
  logic        err_irq;
  logic [7:0]  err_vec;

  always #5 clk = ~clk;

  irq_err_status u_irq_err_status (
    .clk(clk), .rst(rst),
    .det_send_csum(det_send_csum), .det_recv_csum(det_recv_csum),
    .det_send_nacc(det_send_nacc), .det_recv_nacc(det_recv_nacc),
    .send_vec_vld(send_vec_vld), .send_vec(send_vec),
    .recv_vec_vld(recv_vec_vld), .recv_vec(recv_vec),
    .lvt_vec_vld(lvt_vec_vld), .lvt_vec(lvt_vec),
    .self_vec_vld(self_vec_vld), .self_vec(self_vec),
    .win_base(win_base), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .status(status), .err_irq(err_irq), .err_vec(err_vec)
  );

  localparam logic [19:0] BASE = 20'hFEE00;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R10";
  string prev_req = "R10";

  int m_flags, m_copy, m_mask, m_vec, m_irq, m_ivec;

  function automatic bit slot_rsv(int s);
    return !(s == 2 || s == 3 || (s >= 8 && s <= 11) || (s >= 13 && s <= 63));
  endfunction

  task automatic compare();
    vectors++;
    if (status !== m_copy[7:0]) begin
      miscompares++;
      $display("FAIL %s status actual=%h expected=%h", prev_req, status, m_copy[7:0]);
    end
    if (err_irq !== m_irq[0]) begin
      miscompares++;
      $display("FAIL %s err_irq actual=%b expected=%b", prev_req, err_irq, m_irq[0]);
    end
    if (err_vec !== m_ivec[7:0]) begin
      miscompares++;
      $display("FAIL %s err_vec actual=%h expected=%h", prev_req, err_vec, m_ivec[7:0]);
    end
  endtask

  task automatic model_step();
    int sets, old, rise, slot;
    bit inwin, clr, entw;
    if (rst) begin
      m_flags = 0; m_copy = 0; m_mask = 1; m_vec = 0; m_irq = 0; m_ivec = 0;
      return;
    end
    sets = 0;
    if (det_send_csum) sets |= 1;
    if (det_recv_csum) sets |= 2;
    if (det_send_nacc) sets |= 4;
    if (det_recv_nacc) sets |= 8;
    if (send_vec_vld && send_vec < 16) sets |= 32;
    if ((recv_vec_vld && recv_vec < 16) || (lvt_vec_vld && lvt_vec < 16) ||
        (self_vec_vld && self_vec < 16)) sets |= 64;
    inwin = acc_vld && (acc_addr[27:8] == win_base);
    slot  = int'(acc_addr[7:0]);
    if (inwin && slot_rsv(slot)) sets |= 128;
    clr  = inwin && acc_wr && slot == 'h28;
    entw = inwin && acc_wr && slot == 'h37;
    old  = clr ? 0 : m_flags;
    rise = sets & ~old;
    if (clr) m_copy = m_flags;
    m_irq = (rise != 0 && m_mask == 0) ? 1 : 0;
    if (m_irq == 1) m_ivec = m_vec;
    if (entw) begin
      m_vec  = int'(acc_wdata[7:0]);
      m_mask = int'(acc_wdata[8]);
    end
    m_flags = old | sets;
  endtask

  task automatic idle();
    det_send_csum = 0; det_recv_csum = 0; det_send_nacc = 0; det_recv_nacc = 0;
    send_vec_vld = 0; recv_vec_vld = 0; lvt_vec_vld = 0; self_vec_vld = 0;
    send_vec = 8'h40; recv_vec = 8'h40; lvt_vec = 8'h40; self_vec = 8'h40;
    acc_vld = 0; acc_wr = 0; acc_addr = '0; acc_wdata = '0;
  endtask

  task automatic tick(string req);
    compare();
    prev_req = req;
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic acc(bit w, logic [19:0] b, logic [7:0] s, logic [8:0] d);
    acc_vld = 1; acc_wr = w; acc_addr = {b, s}; acc_wdata = d;
  endtask

  task automatic stat_read(string req);
    acc(1, BASE, 8'h28, 9'h0);
    tick(req);
    tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle();
    win_base = BASE;
    rst = 1;
    m_flags = 0; m_copy = 0; m_mask = 1; m_vec = 0; m_irq = 0; m_ivec = 0;
    @(posedge clk);
    @(negedge clk);
    // R10: reset state, including mask set at reset (detection gives no irq)
    repeat (3) tick("R10");
    rst = 0;
    det_send_csum = 1; tick("R10");
    tick("R10");
    stat_read("R10");

    // R9: program entry, vector 0x42, mask clear
    acc(1, BASE, 8'h37, 9'h042); tick("R9");
    // R2 and R7: each detection pulse
    det_send_csum = 1; tick("R7");
    det_send_csum = 1; tick("R7");
    tick("R2");
    det_recv_csum = 1; tick("R2");
    det_send_nacc = 1; tick("R2");
    det_recv_nacc = 1; tick("R2");
    tick("R2");
    stat_read("R1");

    // R3: send vector boundary
    send_vec_vld = 1; send_vec = 8'd16; tick("R3");
    send_vec_vld = 1; send_vec = 8'hFF; tick("R3");
    stat_read("R3");
    send_vec_vld = 1; send_vec = 8'd15; tick("R3");
    stat_read("R3");
    send_vec_vld = 1; send_vec = 8'd0; tick("R3");
    stat_read("R3");

    // R4: receive-side paths
    recv_vec_vld = 1; recv_vec = 8'd16; lvt_vec_vld = 1; lvt_vec = 8'd16;
    self_vec_vld = 1; self_vec = 8'd16; tick("R4");
    stat_read("R4");
    recv_vec_vld = 1; recv_vec = 8'd15; tick("R4");
    stat_read("R4");
    lvt_vec_vld = 1; lvt_vec = 8'd3; tick("R4");
    stat_read("R4");
    self_vec_vld = 1; self_vec = 8'd15; tick("R4");
    stat_read("R4");
    recv_vec = 8'd2; tick("R4");
    stat_read("R4");

    // R5: reserved slot decode
    acc(0, BASE, 8'h02, 9'h0); tick("R5");
    acc(0, BASE, 8'h3F, 9'h0); tick("R5");
    acc(1, BASE, 8'h0B, 9'h0); tick("R5");
    stat_read("R5");
    foreach (m_vec_list[i]) begin end
    acc(0, BASE ^ 20'h1, 8'h01, 9'h0); tick("R5");
    acc(1, 20'h00000, 8'hFF, 9'h0); tick("R5");
    stat_read("R5");
    acc(0, BASE, 8'h01, 9'h0); tick("R5"); stat_read("R5");
    acc(0, BASE, 8'h04, 9'h0); tick("R5"); stat_read("R5");
    acc(1, BASE, 8'h0C, 9'h0); tick("R5"); stat_read("R5");
    acc(0, BASE, 8'h40, 9'h0); tick("R5"); stat_read("R5");
    acc(0, BASE, 8'hFF, 9'h0); tick("R5"); stat_read("R5");

    // R6: detection in same cycle as status write
    det_recv_nacc = 1; tick("R6");
    det_send_csum = 1; acc(1, BASE, 8'h28, 9'h0); tick("R6");
    tick("R6");
    stat_read("R6");
    stat_read("R6");

    // R8: mask set, flags still recorded
    acc(1, BASE, 8'h37, 9'h155); tick("R8");
    det_recv_csum = 1; tick("R8");
    send_vec_vld = 1; send_vec = 8'd1; tick("R8");
    tick("R8");
    stat_read("R8");
    // R9: new vector, unmask, fire
    acc(1, BASE, 8'h37, 9'h0A7); tick("R9");
    det_send_nacc = 1; tick("R9");
    tick("R9");
    acc(1, BASE, 8'h37, 9'h0C3); tick("R9");
    tick("R9");
    stat_read("R9");
    det_send_nacc = 1; tick("R9");
    tick("R9");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 100);
      det_send_csum = ($urandom % 16) == 0;
      det_recv_csum = ($urandom % 16) == 0;
      det_send_nacc = ($urandom % 16) == 0;
      det_recv_nacc = ($urandom % 16) == 0;
      send_vec_vld = ($urandom % 8) == 0; send_vec = 8'($urandom % 40);
      recv_vec_vld = ($urandom % 8) == 0; recv_vec = 8'($urandom % 40);
      lvt_vec_vld  = ($urandom % 8) == 0; lvt_vec  = 8'($urandom % 40);
      self_vec_vld = ($urandom % 8) == 0; self_vec = 8'($urandom);
      if (r < 12) acc(1, BASE, 8'h28, 9'h0);
      else if (r < 16) acc(1, BASE, 8'h37, 9'($urandom));
      else if (r < 24) acc(($urandom % 2) == 1, BASE, 8'($urandom), 9'($urandom));
      else if (r < 28) acc(1, 20'($urandom), 8'($urandom), 9'($urandom));
      tick("R7");
    end

    compare();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  int m_vec_list[1] = '{0};
endmodule